// File: doc/BRIEF.md
# Self-Synchronizing Bit Error Checker

This block measures the bit error count of one receive lane. Recovered serial data arrives as parallel words, one word per cycle when `rx_valid` is high, with bit 0 being the earliest bit on the line. The block holds a local reference sequence. It is either a pseudo-random generator that seeds itself from the incoming data, or a small stored pattern that is replayed in a loop. It compares each received word against this reference and counts the mismatched bits.

A measurement begins with `start`. The block first aligns its reference to the data. It tests that alignment over a window of words and accepts it only if the window holds fewer errors than a programmed threshold. If the window fails, the block realigns and tries again. Once the block is in sync, it accumulates errors and compared bits. It does so either until `stop`, or for a programmed number of words in single-shot mode, which then raises `done` for one cycle.

Top module: `bit_err_checker`

## Requirements
- R1: While reset is asserted and after it is released, `sync_ok`, `done`, `err_count` and `bit_count` are all zero.
- R2: With `cfg_mode`=0 the reference is a 7th-order generator where b[n] = b[n-7] XOR b[n-6]. The first valid word after `start`, or after a failed window, seeds it from its last seven bits. That seed word is not compared. Each following valid word is compared against the next 32 predicted bits.
- R3: With `cfg_mode`=1 the reference is a 4-entry stored pattern. Entry `pat_addr` is written with `pat_wdata` when `pat_we` is high. After `start`, comparison begins at entry 0 with no seed word and steps one entry per valid word, wrapping. A failed window makes the reference skip one extra entry.
- R4: A sync window covers max(`cfg_sync_words`, 32) valid words, which is at least 1024 bits. The window passes when its error total is below max(`cfg_sync_thresh`, 3). `sync_ok` rises with the window's last word, and errors found inside windows are not counted.
- R5: After a failed window `sync_ok` stays low and a new alignment attempt begins at once.
- R6: While in sync, each valid word adds the population count of (received XOR expected) to `err_count` and adds 32 to `bit_count`. Both changes appear at the clock edge that accepts the word.
- R7: A cycle with `rx_valid` low changes neither count nor the alignment, whatever is on `rx_data`.
- R8: `err_count` saturates at all ones instead of wrapping; its width is the parameter ERR_W (32 by default).
- R9: `start` clears both counts, `done` and `sync_ok`, and begins a new alignment. It takes priority over `stop`.
- R10: With `cfg_shot_mode`=1, after max(`cfg_shot_words`, 1) counted words `done` is high for exactly one cycle. After that the counts are frozen and `sync_ok` stays high until the next `start` or `stop`. With `cfg_shot_mode`=0 counting continues until `stop` and `done` never rises.
- R11: `stop` drops `sync_ok` and holds both counts; later words change nothing until the next `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_data | input | 32 | Received word, bit 0 earliest |
| rx_valid | input | 1 | rx_data holds a word this cycle |
| start | input | 1 | Clear counts and begin alignment |
| stop | input | 1 | End the measurement |
| cfg_mode | input | 1 | 0: self-seeding generator, 1: stored pattern |
| cfg_shot_mode | input | 1 | 0: continuous, 1: single shot |
| cfg_sync_thresh | input | 32 | Window error limit (floor 3) |
| cfg_sync_words | input | 32 | Window length in words (floor 32) |
| cfg_shot_words | input | 32 | Single-shot length in words (floor 1) |
| pat_we | input | 1 | Write one stored pattern entry |
| pat_addr | input | 2 | Pattern entry index |
| pat_wdata | input | 32 | Pattern entry data |
| sync_ok | output | 1 | Reference aligned, counting active or finished |
| err_count | output | 32 | Saturating mismatched-bit count |
| bit_count | output | 48 | Compared-bit count |
| done | output | 1 | One-cycle pulse at single-shot completion |

## Verification
All results arrive with zero added latency. `sync_ok`, both counts and `done` take their new value at the same rising edge that accepts the valid word that caused them, and `start` and `stop` act at the edge where they are sampled. The bench drives inputs on falling edges and tags each expected record with the number of the cycle that follows that edge. The monitor compares a record only in that cycle, one nanosecond after the rising edge. The window boundary is checked from both sides, one word before the last and on the last. The one-cycle width of `done` is checked in the cycle after it rises.

// File: rtl/bec_pkg.sv
package bec_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEED,
    ST_SYNC,
    ST_RUN,
    ST_HOLD
  } bec_state_e;
endpackage

// File: rtl/bec_ref_gen.sv
module bec_ref_gen #(
  parameter int W      = 32,
  parameter int ORDER  = 7,
  parameter int TAP    = 6,
  parameter int PAT_AW = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode,
  input  logic              load_seed,
  input  logic              adv,
  input  logic              slip,
  input  logic              restart,
  input  logic [ORDER-1:0]  seed_bits,
  input  logic              pat_we,
  input  logic [PAT_AW-1:0] pat_addr,
  input  logic [W-1:0]      pat_wdata,
  output logic [W-1:0]      exp_word
);
  localparam int PAT_DEPTH = 2 ** PAT_AW;

  logic [W-1:0]      pat_q [PAT_DEPTH];
  logic [ORDER-1:0]  hist_q, hist_d, hist_adv, seed_state;
  logic [W-1:0]      prbs_word;
  logic [PAT_AW-1:0] ptr_q, ptr_d;
  logic              hist_en, ptr_en;

  // stored pattern entries, one register per entry
  for (genvar e = 0; e < PAT_DEPTH; e++) begin : g_pat
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        pat_q[e] <= '0;
      else if (pat_we && (pat_addr == PAT_AW'(e)))
        pat_q[e] <= pat_wdata;
    end
  end

  // hist[j] holds bit n-1-j of the stream
  always_comb begin
    logic [ORDER-1:0] h;
    logic             nb;
    h = hist_q;
    prbs_word = '0;
    for (int i = 0; i < W; i++) begin
      nb = h[ORDER-1] ^ h[TAP-1];
      prbs_word[i] = nb;
      h = {h[ORDER-2:0], nb};
    end
    hist_adv = h;
  end

  always_comb begin
    for (int j = 0; j < ORDER; j++)
      seed_state[j] = seed_bits[ORDER-1-j];
  end

  always_comb begin
    hist_en = load_seed || (adv && !mode);
    hist_d  = load_seed ? seed_state : hist_adv;
    ptr_en  = restart || adv;
    if (restart)
      ptr_d = '0;
    else if (slip)
      ptr_d = ptr_q + PAT_AW'(2);
    else
      ptr_d = ptr_q + PAT_AW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      hist_q <= '0;
    else if (hist_en)
      hist_q <= hist_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      ptr_q <= '0;
    else if (ptr_en)
      ptr_q <= ptr_d;
  end

  assign exp_word = mode ? pat_q[ptr_q] : prbs_word;
endmodule

// File: rtl/bec_counters.sv
module bec_counters #(
  parameter int W     = 32,
  parameter int ERR_W = 32,
  parameter int BIT_W = 48,
  parameter int CFG_W = 32,
  parameter int CW    = $clog2(W + 1),
  parameter int LG    = $clog2(W),
  parameter int RW    = BIT_W - LG
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_all,
  input  logic             clr_win,
  input  logic             win_en,
  input  logic             run_en,
  input  logic [W-1:0]     rx_data,
  input  logic [W-1:0]     exp_word,
  output logic [CW-1:0]    pop,
  output logic [CFG_W-1:0] win_err,
  output logic [CFG_W-1:0] win_words,
  output logic [RW-1:0]    run_words,
  output logic [ERR_W-1:0] err_count,
  output logic [BIT_W-1:0] bit_count
);
  logic [W-1:0]     diff;
  logic [CFG_W:0]   win_sum;
  logic [ERR_W:0]   err_sum;
  logic [CFG_W-1:0] win_err_d, win_words_d;
  logic [ERR_W-1:0] err_d;
  logic [RW-1:0]    run_words_d;
  logic             win_upd, run_upd;

  assign diff = rx_data ^ exp_word;

  always_comb begin
    pop = '0;
    for (int i = 0; i < W; i++)
      pop = pop + CW'(diff[i]);
  end

  always_comb begin
    win_sum = {1'b0, win_err} + (CFG_W + 1)'(pop);
    err_sum = {1'b0, err_count} + (ERR_W + 1)'(pop);
    win_upd = clr_all || clr_win || win_en;
    run_upd = clr_all || run_en;
    if (clr_all || clr_win) begin
      win_err_d   = '0;
      win_words_d = '0;
    end else begin
      win_err_d   = win_sum[CFG_W] ? '1 : win_sum[CFG_W-1:0];
      win_words_d = win_words + CFG_W'(1);
    end
    if (clr_all) begin
      err_d       = '0;
      run_words_d = '0;
    end else begin
      err_d       = err_sum[ERR_W] ? '1 : err_sum[ERR_W-1:0];
      run_words_d = run_words + RW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_err   <= '0;
      win_words <= '0;
    end else if (win_upd) begin
      win_err   <= win_err_d;
      win_words <= win_words_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_count <= '0;
      run_words <= '0;
    end else if (run_upd) begin
      err_count <= err_d;
      run_words <= run_words_d;
    end
  end

  assign bit_count = {run_words, LG'(0)};
endmodule

// File: rtl/bec_sync_fsm.sv
module bec_sync_fsm
  import bec_pkg::*;
#(
  parameter int CFG_W         = 32,
  parameter int CW            = 6,
  parameter int RW            = 43,
  parameter int MIN_WIN_WORDS = 32,
  parameter int MIN_THRESH    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             stop,
  input  logic             rx_valid,
  input  logic             mode,
  input  logic             shot_mode,
  input  logic [CFG_W-1:0] thresh,
  input  logic [CFG_W-1:0] sync_words,
  input  logic [CFG_W-1:0] shot_words,
  input  logic [CW-1:0]    pop,
  input  logic [CFG_W-1:0] win_err,
  input  logic [CFG_W-1:0] win_words,
  input  logic [RW-1:0]    run_words,
  output logic             load_seed,
  output logic             adv,
  output logic             slip,
  output logic             restart,
  output logic             clr_all,
  output logic             clr_win,
  output logic             win_en,
  output logic             run_en,
  output logic             sync_ok,
  output logic             done
);
  localparam int SW = (RW + 1 > CFG_W + 1) ? RW + 1 : CFG_W + 1;

  bec_state_e       state_q, state_d;
  logic             done_d;
  logic [CFG_W-1:0] thr_eff, win_len, shot_len;
  logic             win_last, win_pass, shot_last;

  always_comb begin
    thr_eff  = (thresh < CFG_W'(MIN_THRESH)) ? CFG_W'(MIN_THRESH) : thresh;
    win_len  = (sync_words < CFG_W'(MIN_WIN_WORDS)) ? CFG_W'(MIN_WIN_WORDS) : sync_words;
    shot_len = (shot_words == '0) ? CFG_W'(1) : shot_words;
    win_last  = ({1'b0, win_words} + (CFG_W + 1)'(1)) >= {1'b0, win_len};
    win_pass  = ({1'b0, win_err} + (CFG_W + 1)'(pop)) < {1'b0, thr_eff};
    shot_last = (SW'(run_words) + SW'(1)) >= SW'(shot_len);
  end

  always_comb begin
    state_d   = state_q;
    done_d    = 1'b0;
    load_seed = 1'b0;
    adv       = 1'b0;
    slip      = 1'b0;
    restart   = 1'b0;
    clr_all   = 1'b0;
    clr_win   = 1'b0;
    win_en    = 1'b0;
    run_en    = 1'b0;
    if (start) begin
      clr_all = 1'b1;
      clr_win = 1'b1;
      restart = 1'b1;
      state_d = mode ? ST_SYNC : ST_SEED;
    end else if (stop) begin
      state_d = ST_IDLE;
    end else if (rx_valid) begin
      unique case (state_q)
        ST_SEED: begin
          load_seed = 1'b1;
          state_d   = ST_SYNC;
        end
        ST_SYNC: begin
          adv    = 1'b1;
          win_en = 1'b1;
          if (win_last) begin
            clr_win = 1'b1;
            if (win_pass)
              state_d = ST_RUN;
            else if (mode)
              slip = 1'b1;
            else
              state_d = ST_SEED;
          end
        end
        ST_RUN: begin
          adv    = 1'b1;
          run_en = 1'b1;
          if (shot_mode && shot_last) begin
            state_d = ST_HOLD;
            done_d  = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done    <= 1'b0;
    end else begin
      state_q <= state_d;
      done    <= done_d;
    end
  end

  assign sync_ok = (state_q == ST_RUN) || (state_q == ST_HOLD);
endmodule

// File: rtl/bit_err_checker.sv
module bit_err_checker #(
  parameter int W             = 32,
  parameter int ERR_W         = 32,
  parameter int BIT_W         = 48,
  parameter int CFG_W         = 32,
  parameter int ORDER         = 7,
  parameter int TAP           = 6,
  parameter int PAT_AW        = 2,
  parameter int MIN_WIN_BITS  = 1024,
  parameter int MIN_THRESH    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [W-1:0]      rx_data,
  input  logic              rx_valid,
  input  logic              start,
  input  logic              stop,
  input  logic              cfg_mode,
  input  logic              cfg_shot_mode,
  input  logic [CFG_W-1:0]  cfg_sync_thresh,
  input  logic [CFG_W-1:0]  cfg_sync_words,
  input  logic [CFG_W-1:0]  cfg_shot_words,
  input  logic              pat_we,
  input  logic [PAT_AW-1:0] pat_addr,
  input  logic [W-1:0]      pat_wdata,
  output logic              sync_ok,
  output logic [ERR_W-1:0]  err_count,
  output logic [BIT_W-1:0]  bit_count,
  output logic              done
);
  localparam int CW            = $clog2(W + 1);
  localparam int LG            = $clog2(W);
  localparam int RW            = BIT_W - LG;
  localparam int MIN_WIN_WORDS = MIN_WIN_BITS / W;

  logic [W-1:0]     exp_word;
  logic [CW-1:0]    pop;
  logic [CFG_W-1:0] win_err, win_words;
  logic [RW-1:0]    run_words;
  logic             load_seed, adv, slip, restart;
  logic             clr_all, clr_win, win_en, run_en;

  bec_ref_gen #(
    .W(W), .ORDER(ORDER), .TAP(TAP), .PAT_AW(PAT_AW)
  ) ref_i (
    .clk(clk), .rst_n(rst_n), .mode(cfg_mode),
    .load_seed(load_seed), .adv(adv), .slip(slip), .restart(restart),
    .seed_bits(rx_data[W-1 -: ORDER]),
    .pat_we(pat_we), .pat_addr(pat_addr), .pat_wdata(pat_wdata),
    .exp_word(exp_word)
  );

  bec_counters #(
    .W(W), .ERR_W(ERR_W), .BIT_W(BIT_W), .CFG_W(CFG_W),
    .CW(CW), .LG(LG), .RW(RW)
  ) cnt_i (
    .clk(clk), .rst_n(rst_n), .clr_all(clr_all), .clr_win(clr_win),
    .win_en(win_en), .run_en(run_en), .rx_data(rx_data), .exp_word(exp_word),
    .pop(pop), .win_err(win_err), .win_words(win_words), .run_words(run_words),
    .err_count(err_count), .bit_count(bit_count)
  );

  bec_sync_fsm #(
    .CFG_W(CFG_W), .CW(CW), .RW(RW),
    .MIN_WIN_WORDS(MIN_WIN_WORDS), .MIN_THRESH(MIN_THRESH)
  ) fsm_i (
    .clk(clk), .rst_n(rst_n), .start(start), .stop(stop), .rx_valid(rx_valid),
    .mode(cfg_mode), .shot_mode(cfg_shot_mode),
    .thresh(cfg_sync_thresh), .sync_words(cfg_sync_words), .shot_words(cfg_shot_words),
    .pop(pop), .win_err(win_err), .win_words(win_words), .run_words(run_words),
    .load_seed(load_seed), .adv(adv), .slip(slip), .restart(restart),
    .clr_all(clr_all), .clr_win(clr_win), .win_en(win_en), .run_en(run_en),
    .sync_ok(sync_ok), .done(done)
  );
endmodule

// File: rtl/bec_checker.sv
module bec_checker #(
  parameter int ERR_W = 32,
  parameter int BIT_W = 48
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rx_valid,
  input logic             start,
  input logic             stop,
  input logic             cfg_shot_mode,
  input logic             sync_ok,
  input logic             done,
  input logic [ERR_W-1:0] err_count,
  input logic [BIT_W-1:0] bit_count
);
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R10
  AST_DONE_SHOT_ONLY: assert property (@(posedge clk) disable iff (!rst_n) done |-> cfg_shot_mode && sync_ok); // R10
  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) start |=> (err_count == '0) && (bit_count == '0) && !sync_ok); // R9
  AST_ERR_SATURATE: assert property (@(posedge clk) disable iff (!rst_n) ((&err_count) && !start) |=> (&err_count)); // R8
  AST_ERR_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n) !start |=> err_count >= $past(err_count)); // R8
  AST_IDLE_NO_COUNT: assert property (@(posedge clk) disable iff (!rst_n) (!rx_valid && !start) |=> $stable(err_count) && $stable(bit_count)); // R7
  AST_NO_COUNT_UNSYNCED: assert property (@(posedge clk) disable iff (!rst_n) (!sync_ok && !start) |=> $stable(bit_count) && $stable(err_count)); // R6
  AST_WORD_STEP: assert property (@(posedge clk) disable iff (!rst_n) !start |=> (bit_count == $past(bit_count)) || (bit_count == $past(bit_count) + BIT_W'(32))); // R6
  AST_STOP_DROPS: assert property (@(posedge clk) disable iff (!rst_n) (stop && !start) |=> !sync_ok); // R11
endmodule

bind bit_err_checker bec_checker #(.ERR_W(ERR_W), .BIT_W(BIT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .start(start), .stop(stop),
  .cfg_shot_mode(cfg_shot_mode), .sync_ok(sync_ok), .done(done),
  .err_count(err_count), .bit_count(bit_count)
);

// File: tb/bit_err_checker_tb_top.sv
module bit_err_checker_tb_top;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int SMALL_ERR_W = 10;
  localparam longint SMALL_MAX = (64'd1 << SMALL_ERR_W) - 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] rx_data = '0;
  logic        rx_valid = 1'b0, start = 1'b0, stop = 1'b0;
  logic        cfg_mode = 1'b0, cfg_shot_mode = 1'b0;
  logic [31:0] cfg_sync_thresh = 32'd3, cfg_sync_words = 32'd32, cfg_shot_words = 32'd0;
  logic        pat_we = 1'b0;
  logic [1:0]  pat_addr = '0;
  logic [31:0] pat_wdata = '0;
  logic        sync_ok, done, sync_ok_s, done_s;
  logic [31:0] err_count;
  logic [SMALL_ERR_W-1:0] err_count_s;
  logic [47:0] bit_count, bit_count_s;

  always #2 clk = ~clk;

  bit_err_checker dut_i (
    .clk(clk), .rst_n(rst_n), .rx_data(rx_data), .rx_valid(rx_valid),
    .start(start), .stop(stop), .cfg_mode(cfg_mode), .cfg_shot_mode(cfg_shot_mode),
    .cfg_sync_thresh(cfg_sync_thresh), .cfg_sync_words(cfg_sync_words),
    .cfg_shot_words(cfg_shot_words), .pat_we(pat_we), .pat_addr(pat_addr),
    .pat_wdata(pat_wdata), .sync_ok(sync_ok), .err_count(err_count),
    .bit_count(bit_count), .done(done)
  );

  bit_err_checker #(.ERR_W(SMALL_ERR_W)) dut_sat_i (
    .clk(clk), .rst_n(rst_n), .rx_data(rx_data), .rx_valid(rx_valid),
    .start(start), .stop(stop), .cfg_mode(cfg_mode), .cfg_shot_mode(cfg_shot_mode),
    .cfg_sync_thresh(cfg_sync_thresh), .cfg_sync_words(cfg_sync_words),
    .cfg_shot_words(cfg_shot_words), .pat_we(pat_we), .pat_addr(pat_addr),
    .pat_wdata(pat_wdata), .sync_ok(sync_ok_s), .err_count(err_count_s),
    .bit_count(bit_count_s), .done(done_s)
  );

  typedef struct {
    int unsigned at;
    string       req;
    logic        sync;
    longint      err;
    longint      bits;
    logic        dn;
  } exp_t;

  exp_t        sbq[$];
  int unsigned cyc = 0;
  int          tests = 0, fails = 0;
  bit          finished = 1'b0;

  longint m_err = 0, m_bits = 0;
  logic   m_sync = 1'b0, m_done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  // reference stream: g[k] is bit n-1-k
  logic [6:0] gsr = 7'h5B;
  function automatic logic [31:0] gen_word();
    logic [31:0] w;
    logic        nb;
    for (int i = 0; i < 32; i++) begin
      nb = gsr[6] ^ gsr[5];
      w[i] = nb;
      gsr = {gsr[5:0], nb};
    end
    return w;
  endfunction

  task automatic push(input string req);
    exp_t e;
    e.at = cyc + 1; e.req = req; e.sync = m_sync;
    e.err = m_err; e.bits = m_bits; e.dn = m_done;
    sbq.push_back(e);
  endtask

  // monitor: compares each record one ns after the edge it belongs to
  initial forever begin
    @(posedge clk);
    #1;
    while (sbq.size() > 0 && sbq[0].at == cyc) begin
      exp_t   e;
      longint es;
      e  = sbq.pop_front();
      es = (e.err > SMALL_MAX) ? SMALL_MAX : e.err;
      tests++;
      if (sync_ok !== e.sync || done !== e.dn || longint'(err_count) != e.err ||
          longint'(bit_count) != e.bits || longint'(err_count_s) != es ||
          sync_ok_s !== e.sync || longint'(bit_count_s) != e.bits) begin
        fails++;
        $display("FAIL %s @%0d: sync=%0b exp %0b done=%0b exp %0b err=%0d exp %0d err_small=%0d exp %0d bits=%0d exp %0d",
                 e.req, cyc, sync_ok, e.sync, done, e.dn, err_count, e.err,
                 err_count_s, es, bit_count, e.bits);
      end
    end
  end

  task automatic drive(input logic [31:0] d, input logic v, input logic st, input logic sp);
    @(negedge clk);
    rx_data = d; rx_valid = v; start = st; stop = sp; pat_we = 1'b0;
  endtask

  task automatic do_start();
    drive(32'hDEAD_BEEF, 1'b1, 1'b1, 1'b0);
    m_err = 0; m_bits = 0; m_sync = 1'b0; m_done = 1'b0;
    push("R9");
  endtask

  task automatic do_stop();
    drive(32'h0, 1'b0, 1'b0, 1'b1);
    m_sync = 1'b0;
    push("R11");
  endtask

  task automatic seed();
    drive(gen_word(), 1'b1, 1'b0, 1'b0);
  endtask

  // 32-word window; one word (index fi) carries flip mask fm
  task automatic window(input int fi, input logic [31:0] fm, input logic pass, input string req);
    for (int i = 0; i < 32; i++) begin
      logic [31:0] d;
      d = gen_word();
      if (i == fi) d = d ^ fm;
      drive(d, 1'b1, 1'b0, 1'b0);
      if (i == 30) push("R4");
      if (i == 31) begin
        m_sync = pass;
        push(req);
      end
    end
  endtask

  task automatic run_word(input logic [31:0] fm, input string req);
    drive(gen_word() ^ fm, 1'b1, 1'b0, 1'b0);
    m_err  = m_err + $countones(fm);
    m_bits = m_bits + 32;
    push(req);
  endtask

  task automatic idle(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      drive(32'hA5A5_5A5A ^ 32'(i), 1'b0, 1'b0, 1'b0);
      push(req);
    end
  endtask

  task automatic pat_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    rx_valid = 1'b0; start = 1'b0; stop = 1'b0;
    pat_we = 1'b1; pat_addr = a; pat_wdata = d;
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: run did not complete, actual hung expected finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  logic [31:0] pat[4];

  initial begin
    pat[0] = 32'h0000_0000; pat[1] = 32'hFFFF_0000;
    pat[2] = 32'h00FF_00FF; pat[3] = 32'h0F0F_0F0F;

    // R1: reset state
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(2, "R1");

    // R2 R4 R6: self-seeding generator, clean window, then counted errors
    do_start();
    seed();
    window(-1, 32'h0, 1'b1, "R2");
    run_word(32'h0000_0700, "R6");
    run_word(32'h0, "R2");
    run_word(32'h8000_0001, "R6");
    idle(3, "R7");
    run_word(32'h0, "R7");
    run_word(32'h0, "R6");

    // R11: stop holds counts and ignores later words
    do_stop();
    drive(32'hFFFF_FFFF, 1'b1, 1'b0, 1'b0); push("R11");
    drive(32'h1234_5678, 1'b1, 1'b0, 1'b0); push("R11");

    // R5: first window has 4 errors and fails, reseed, second passes with 2
    do_start();
    seed();
    window(3, 32'h0000_000F, 1'b0, "R5");
    seed();
    window(10, 32'h0001_0001, 1'b1, "R4");
    run_word(32'h0, "R6");
    do_stop();

    // R4: thresholds and window lengths below the floors are raised to them
    cfg_sync_thresh = 32'd0;
    cfg_sync_words  = 32'd5;
    do_start();
    seed();
    window(7, 32'h0000_0300, 1'b1, "R4");
    run_word(32'h0000_0001, "R6");
    do_stop();
    cfg_sync_thresh = 32'd3;
    cfg_sync_words  = 32'd32;

    // R10: single shot of 4 words
    cfg_shot_mode  = 1'b1;
    cfg_shot_words = 32'd4;
    do_start();
    seed();
    window(-1, 32'h0, 1'b1, "R4");
    run_word(32'h0000_0010, "R10");
    run_word(32'h0, "R10");
    run_word(32'h0, "R10");
    m_done = 1'b1;
    run_word(32'h0, "R10");
    m_done = 1'b0;
    drive(32'hFFFF_FFFF, 1'b1, 1'b0, 1'b0); push("R10");
    drive(32'hFFFF_FFFF, 1'b1, 1'b0, 1'b0); push("R10");
    do_stop();
    cfg_shot_mode  = 1'b0;
    cfg_shot_words = 32'd0;

    // R8: fully inverted words drive the narrow instance into saturation
    do_start();
    seed();
    window(-1, 32'h0, 1'b1, "R4");
    for (int i = 0; i < 40; i++) begin
      drive(~gen_word(), 1'b1, 1'b0, 1'b0);
      m_err  = m_err + 32;
      m_bits = m_bits + 32;
      if (i == 30 || i == 31 || i == 32 || i == 39) push("R8");
    end
    do_stop();

    // R3: stored pattern, data one entry ahead; first window fails, skip aligns
    for (int a = 0; a < 4; a++) pat_write(2'(a), pat[a]);
    cfg_mode = 1'b1;
    do_start();
    for (int k = 0; k < 64; k++) begin
      drive(pat[(k + 1) % 4], 1'b1, 1'b0, 1'b0);
      if (k == 31) push("R3");
      if (k == 62) push("R4");
      if (k == 63) begin
        m_sync = 1'b1;
        push("R3");
      end
    end
    for (int k = 64; k < 68; k++) begin
      logic [31:0] fm;
      fm = (k == 66) ? 32'h0101_0107 : 32'h0;
      drive(pat[(k + 1) % 4] ^ fm, 1'b1, 1'b0, 1'b0);
      m_err  = m_err + $countones(fm);
      m_bits = m_bits + 32;
      push("R3");
    end
    do_stop();
    cfg_mode = 1'b0;

    idle(3, "R11");
    repeat (2) @(negedge clk);
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule